// File: doc/BRIEF.md
# Move-Only Transport-Triggered Processor

This block is a minimal processor whose single instruction copies one word from a source address to a destination address. There is no opcode field. Every instruction is a pair of words in memory: the source address comes first and the destination address second. Arithmetic, branching, reading and writing the program counter, and indirect addressing all happen as side effects of reads from, or writes to, a small window of reserved addresses at the top of the address space. Accesses to that window go to internal units and never appear as memory writes on the bus. The one exception is the pointer value slot, which forwards the access to the word that the pointer selects.

Code and data share a single word-addressed memory port. Every instruction takes exactly four cycles: fetch the source address, fetch the destination address, read the source, write the destination. The bus has no handshake. The memory must return read data combinationally in the same cycle that the address is presented, and it must accept a write on the clock edge that ends a cycle in which the write enable is high. Control pins are plain levels.

Top module: `mtp_core`

## Requirements
- R1: After reset, instructions run in a fixed four-cycle pattern. The bus address is PC in cycle 1, PC+1 in cycle 2, the source address in cycle 3 and the destination address in cycle 4. The program counter advances by 2 after the second fetch.
- R2: A move between two ordinary addresses copies the word. The write enable is high only in the fourth cycle, with the destination address and the copied data on the bus.
- R3: Addresses 0xFFF0 to 0xFFFF form the reserved window. A move whose destination is in the window, other than the pointer value slot 0xFFFA, produces no bus write.
- R4: Operand slot A is 0xFFF0 and operand slot B is 0xFFF1. Reading 0xFFF2 returns A+B and reading 0xFFF3 returns A-B, both modulo 2^16.
- R5: Reading the program counter slot 0xFFF4 returns the address of the next instruction. This is the address of the current instruction plus 2.
- R6: A write to 0xFFF4 sets the address of the next fetch and overrides the automatic increment.
- R7: The branch unit has three slots: condition 0xFFF5, taken target 0xFFF6 and not-taken target 0xFFF7. Reading 0xFFF8 returns the taken target when the condition is nonzero and the not-taken target when it is zero. Moving 0xFFF8 into 0xFFF4 therefore performs a conditional jump.
- R8: Writing 0xFFF9 sets the pointer. A read of 0xFFFA reads the memory word at the pointer address, and a write to 0xFFFA writes the bus at the pointer address.
- R9: A synchronous reset clears the program counter and every unit register to 0. While reset is held, the bus shows address 0 with the write enable low.
- R10: Writes to the read-only slots 0xFFF2, 0xFFF3 and 0xFFF8, and to the unused slots 0xFFFB to 0xFFFF, change nothing. Reading an unused slot returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Word address of the current bus cycle |
| mem_wdata | output | 16 | Data to write |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| mem_we | output | 1 | Write strobe for the current cycle |

## Verification
The assertions assume that the memory answers a read in the same cycle it is addressed, and that reset is held for at least one clock edge before the first instruction. The stimulus uses a bench memory with combinational reads and releases reset away from the clock edge. The assertions also assume that a pointer aimed at the reserved window is not followed by a store through the value slot. The test program keeps its pointer in ordinary memory. Both branch directions are exercised: one with a zero condition and one with a nonzero condition. A decoy block sits at the target that must not be taken, so any wrong branch shows up as an unexpected bus write.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
  typedef enum logic [1:0] {
    PH_FSRC  = 2'd0,
    PH_FDST  = 2'd1,
    PH_READ  = 2'd2,
    PH_WRITE = 2'd3
  } phase_t;

  // slot offsets inside the reserved window
  localparam int unsigned SL_OPA  = 0;
  localparam int unsigned SL_OPB  = 1;
  localparam int unsigned SL_SUM  = 2;
  localparam int unsigned SL_DIF  = 3;
  localparam int unsigned SL_PC   = 4;
  localparam int unsigned SL_CND  = 5;
  localparam int unsigned SL_TKN  = 6;
  localparam int unsigned SL_NTK  = 7;
  localparam int unsigned SL_SEL  = 8;
  localparam int unsigned SL_PTRA = 9;
  localparam int unsigned SL_PTRV = 10;
  localparam int unsigned SL_COUNT = 11;
endpackage

// File: rtl/mtp_alu.sv
module mtp_alu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] dif_o
);
  logic [DW-1:0] a_q, b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (wr_a) a_q <= wdata;
      if (wr_b) b_q <= wdata;
    end
  end

  assign a_o   = a_q;
  assign b_o   = b_q;
  assign sum_o = a_q + b_q;
  assign dif_o = a_q - b_q;

  // R4
  alu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_a && !wr_b) |=> ($stable(sum_o) && $stable(dif_o)));
endmodule

// File: rtl/mtp_branch.sv
module mtp_branch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_c,
  input  logic          wr_t,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnd_o,
  output logic [DW-1:0] tkn_o,
  output logic [DW-1:0] ntk_o,
  output logic [DW-1:0] sel_o
);
  logic [DW-1:0] c_q, t_q, n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_q <= '0;
      t_q <= '0;
      n_q <= '0;
    end else begin
      if (wr_c) c_q <= wdata;
      if (wr_t) t_q <= wdata;
      if (wr_n) n_q <= wdata;
    end
  end

  assign cnd_o = c_q;
  assign tkn_o = t_q;
  assign ntk_o = n_q;
  assign sel_o = (c_q != '0) ? t_q : n_q;

  // R7
  br_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_c && !wr_t && !wr_n) |=> $stable(sel_o));
endmodule

// File: rtl/mtp_ptr.sv
module mtp_ptr #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ptr_o
);
  logic [DW-1:0] p_q;

  always_ff @(posedge clk) begin
    if (rst)     p_q <= '0;
    else if (wr) p_q <= wdata;
  end

  assign ptr_o = p_q;

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(ptr_o));
endmodule

// File: rtl/mtp_core.sv
module mtp_core
  import mtp_pkg::*;
#(
  parameter int DW       = 16,
  parameter int WIN_BITS = 4
) (
  input  logic          clk,
  input  logic          rst,
  output logic [15:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          mem_we
);
  localparam int AW  = DW;
  localparam int HIW = AW - WIN_BITS;
  localparam int NSL = 1 << WIN_BITS;

  phase_t        ph_q;
  logic [AW-1:0] pc_q, src_q, dst_q;
  logic [DW-1:0] dat_q;

  // address decode
  logic                src_sp, dst_sp;
  logic [WIN_BITS-1:0] src_of, dst_of;
  assign src_sp = &src_q[AW-1:WIN_BITS];
  assign dst_sp = &dst_q[AW-1:WIN_BITS];
  assign src_of = src_q[WIN_BITS-1:0];
  assign dst_of = dst_q[WIN_BITS-1:0];

  logic src_pv, dst_pv;
  assign src_pv = src_sp && (src_of == WIN_BITS'(SL_PTRV));
  assign dst_pv = dst_sp && (dst_of == WIN_BITS'(SL_PTRV));

  // per-slot write strobes
  logic          wr_win;
  logic [NSL-1:0] slot_wr;
  assign wr_win = (ph_q == PH_WRITE) && dst_sp;

  for (genvar g = 0; g < NSL; g++) begin : g_wdec
    assign slot_wr[g] = wr_win && (dst_of == WIN_BITS'(g));
  end

  // units
  logic [DW-1:0] a_v, b_v, sum_v, dif_v, cnd_v, tkn_v, ntk_v, sel_v, ptr_v;

  mtp_alu #(.DW(DW)) u_alu (
    .clk(clk), .rst(rst),
    .wr_a(slot_wr[SL_OPA]), .wr_b(slot_wr[SL_OPB]),
    .wdata(dat_q),
    .a_o(a_v), .b_o(b_v), .sum_o(sum_v), .dif_o(dif_v)
  );

  mtp_branch #(.DW(DW)) u_br (
    .clk(clk), .rst(rst),
    .wr_c(slot_wr[SL_CND]), .wr_t(slot_wr[SL_TKN]), .wr_n(slot_wr[SL_NTK]),
    .wdata(dat_q),
    .cnd_o(cnd_v), .tkn_o(tkn_v), .ntk_o(ntk_v), .sel_o(sel_v)
  );

  mtp_ptr #(.DW(DW)) u_ptr (
    .clk(clk), .rst(rst),
    .wr(slot_wr[SL_PTRA]), .wdata(dat_q), .ptr_o(ptr_v)
  );

  // read mux over the window
  logic [DW-1:0] slot_rd;
  always_comb begin
    unique case (int'(src_of))
      SL_OPA:  slot_rd = a_v;
      SL_OPB:  slot_rd = b_v;
      SL_SUM:  slot_rd = sum_v;
      SL_DIF:  slot_rd = dif_v;
      SL_PC:   slot_rd = pc_q;
      SL_CND:  slot_rd = cnd_v;
      SL_TKN:  slot_rd = tkn_v;
      SL_NTK:  slot_rd = ntk_v;
      SL_SEL:  slot_rd = sel_v;
      SL_PTRA: slot_rd = ptr_v;
      default: slot_rd = '0;
    endcase
  end

  // bus drive
  always_comb begin
    mem_we    = 1'b0;
    mem_wdata = dat_q;
    unique case (ph_q)
      PH_FSRC:  mem_addr = pc_q;
      PH_FDST:  mem_addr = pc_q + AW'(1);
      PH_READ:  mem_addr = src_pv ? ptr_v : src_q;
      default: begin
        mem_addr = dst_pv ? ptr_v : dst_q;
        mem_we   = !dst_sp || dst_pv;
      end
    endcase
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_FSRC;
      pc_q  <= '0;
      src_q <= '0;
      dst_q <= '0;
      dat_q <= '0;
    end else begin
      unique case (ph_q)
        PH_FSRC: begin
          src_q <= mem_rdata;
          ph_q  <= PH_FDST;
        end
        PH_FDST: begin
          dst_q <= mem_rdata;
          pc_q  <= pc_q + AW'(2);
          ph_q  <= PH_READ;
        end
        PH_READ: begin
          dat_q <= (src_sp && !src_pv) ? slot_rd : mem_rdata;
          ph_q  <= PH_WRITE;
        end
        default: begin
          if (slot_wr[SL_PC]) pc_q <= dat_q;
          ph_q <= PH_FSRC;
        end
      endcase
    end
  end

  // R1
  seq_order_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_WRITE) |=> (ph_q == PH_FSRC));
  // R1
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_WRITE) |=> (ph_q == phase_t'($past(ph_q) + 2'd1)));
  // R1
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_FDST) |=> (pc_q == $past(pc_q) + AW'(2)));
  // R2
  we_phase_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (ph_q == PH_WRITE));
  // R3
  win_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !dst_pv) |-> !(&mem_addr[AW-1:WIN_BITS]));
  // R6
  pc_jump_chk: assert property (@(posedge clk) disable iff (rst)
    ((ph_q == PH_WRITE) && dst_sp && (dst_of == WIN_BITS'(SL_PC)))
      |=> (pc_q == $past(dat_q)));
  // R9
  rst_bus_chk: assert property (@(posedge clk)
    rst |=> (!mem_we && (mem_addr == '0)));
endmodule

// File: tb/sim_mtp_core.sv
module sim_mtp_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we;

  always #2 clk = ~clk;

  mtp_core u0 (
    .clk(clk), .rst(rst),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we)
  );

  logic [15:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  typedef struct {
    logic [15:0] pc;
    bit          wr;
    logic [15:0] wa;
    logic [15:0] wd;
    string       rq;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // driver: place one instruction; optionally push its expectation
  task automatic put(input logic [15:0] at, input logic [15:0] s, input logic [15:0] d,
                     input bit push, input bit wr, input logic [15:0] wa,
                     input logic [15:0] wd, input string rq);
    item_t it;
    mem[at[9:0]]      = s;
    mem[at[9:0] + 1]  = d;
    if (push) begin
      it.pc = at; it.wr = wr; it.wa = wa; it.wd = wd; it.rq = rq;
      q.push_back(it);
    end
  endtask

  task automatic expect_only(input logic [15:0] at, input string rq);
    item_t it;
    it.pc = at; it.wr = 1'b0; it.wa = '0; it.wd = '0; it.rq = rq;
    q.push_back(it);
  endtask

  // monitor
  bit    active = 1'b0;
  bit    run = 1'b0;
  item_t cur;
  int    ph = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (run && !rst) begin
        case (ph)
          0: begin
            if (q.size() > 0) begin
              cur = q.pop_front();
              active = 1'b1;
              // R1 / R6: fetch address follows program flow
              check(mem_addr == cur.pc, {"R1/R6 fetch ", cur.rq}, mem_addr, cur.pc);
              check(!mem_we, "R2 no write in fetch", {15'd0, mem_we}, 16'd0);
            end else active = 1'b0;
          end
          1: if (active) check(mem_addr == cur.pc + 16'd1, "R1 second fetch", mem_addr, cur.pc + 16'd1);
          2: if (active) check(!mem_we, "R2 no write in read", {15'd0, mem_we}, 16'd0);
          default: if (active) begin
            if (cur.wr) begin
              check(mem_we, {"R2 write strobe ", cur.rq}, {15'd0, mem_we}, 16'd1);
              check(mem_addr == cur.wa, {"waddr ", cur.rq}, mem_addr, cur.wa);
              check(mem_wdata == cur.wd, {"wdata ", cur.rq}, mem_wdata, cur.wd);
            end else begin
              // R3 / R10: window writes stay off the bus
              check(!mem_we, {"R3 no bus write ", cur.rq}, {15'd0, mem_we}, 16'd0);
            end
          end
        endcase
        ph = (ph + 1) % 4;
      end
    end
  end

  initial begin
    int cyc;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
    mem[10'h100] = 16'h1234;
    mem[10'h101] = 16'h0005;
    mem[10'h102] = 16'h1235;
    mem[10'h103] = 16'h0300;
    mem[10'h104] = 16'h0000;
    mem[10'h105] = 16'h0060;
    mem[10'h106] = 16'h0040;
    mem[10'h107] = 16'h0080;
    mem[10'h108] = 16'h0084;
    mem[10'h300] = 16'hBEEF;
    mem[10'h20F] = 16'h5A5A;

    put(16'h0000, 16'h0100, 16'h0200, 1, 1, 16'h0200, 16'h1234, "R2 plain copy");
    put(16'h0002, 16'h0100, 16'hFFF0, 1, 0, 0, 0, "R4 load A");
    put(16'h0004, 16'h0101, 16'hFFF1, 1, 0, 0, 0, "R4 load B");
    put(16'h0006, 16'hFFF2, 16'h0201, 1, 1, 16'h0201, 16'h1239, "R4 sum");
    put(16'h0008, 16'hFFF3, 16'h0202, 1, 1, 16'h0202, 16'h122F, "R4 diff");
    put(16'h000A, 16'h0102, 16'hFFF1, 1, 0, 0, 0, "R4 reload B");
    put(16'h000C, 16'hFFF3, 16'h0203, 1, 1, 16'h0203, 16'hFFFF, "R4 diff wrap");
    put(16'h000E, 16'hFFF4, 16'h0204, 1, 1, 16'h0204, 16'h0010, "R5 pc read");
    put(16'h0010, 16'hFFFF, 16'h0205, 1, 1, 16'h0205, 16'h0000, "R10 unused reads zero");
    put(16'h0012, 16'h0100, 16'hFFF2, 1, 0, 0, 0, "R10 write to sum slot");
    put(16'h0014, 16'hFFF2, 16'h0206, 1, 1, 16'h0206, 16'h2469, "R10 sum unchanged");
    put(16'h0016, 16'h0103, 16'hFFF9, 1, 0, 0, 0, "R8 set pointer");
    put(16'h0018, 16'hFFFA, 16'h0207, 1, 1, 16'h0207, 16'hBEEF, "R8 load via pointer");
    put(16'h001A, 16'h0100, 16'hFFFA, 1, 1, 16'h0300, 16'h1234, "R8 store via pointer");
    put(16'h001C, 16'h0104, 16'hFFF5, 1, 0, 0, 0, "R7 cond zero");
    put(16'h001E, 16'h0105, 16'hFFF6, 1, 0, 0, 0, "R7 taken target");
    put(16'h0020, 16'h0106, 16'hFFF7, 1, 0, 0, 0, "R7 not-taken target");
    put(16'h0022, 16'hFFF8, 16'hFFF4, 1, 0, 0, 0, "R7 branch not taken");
    put(16'h0040, 16'h0100, 16'h0208, 1, 1, 16'h0208, 16'h1234, "R6 landed at not-taken");
    put(16'h0042, 16'h0101, 16'hFFF5, 1, 0, 0, 0, "R7 cond nonzero");
    put(16'h0044, 16'h0107, 16'hFFF6, 1, 0, 0, 0, "R7 taken target 2");
    put(16'h0046, 16'h0105, 16'hFFF7, 1, 0, 0, 0, "R7 not-taken target 2");
    put(16'h0048, 16'hFFF8, 16'hFFF4, 1, 0, 0, 0, "R7 branch taken");
    put(16'h0060, 16'h0101, 16'h020F, 0, 0, 0, 0, "decoy");
    put(16'h0080, 16'h0100, 16'h0209, 1, 1, 16'h0209, 16'h1234, "R6 landed at taken");
    put(16'h0082, 16'hFFF4, 16'h020A, 1, 1, 16'h020A, 16'h0084, "R5 pc read after jump");
    put(16'h0084, 16'h0108, 16'hFFF4, 1, 0, 0, 0, "R6 self jump");
    expect_only(16'h0084, "R6 hold loop");
    expect_only(16'h0084, "R6 hold loop");

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state on the bus
    check(mem_addr == 16'h0000, "R9 reset address", mem_addr, 16'h0000);
    check(!mem_we, "R9 reset strobe", {15'd0, mem_we}, 16'd0);
    @(posedge clk);
    #1 rst = 1'b0;
    run = 1'b1;

    cyc = 0;
    while ((q.size() != 0 || active) && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 5000) check(1'b0, "watchdog", 16'(cyc), 16'd0);
    repeat (8) @(posedge clk);
    #1;
    check(mem[10'h300] == 16'h1234, "R8 pointer store landed", mem[10'h300], 16'h1234);
    check(mem[10'h20F] == 16'h5A5A, "R7 decoy untouched", mem[10'h20F], 16'h5A5A);
    check(mem[10'h200] == 16'h1234, "R2 copy landed", mem[10'h200], 16'h1234);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule